// File: doc/BRIEF.md
# Output Compare Timer Channel

This block is one compare channel of a free-running timer, reached from an 8-bit processor bus. A prescaler divides the bus clock, and a 16-bit up-counter advances on each prescaled tick. Software loads a 16-bit compare value as two byte locations. When the counter steps onto that value, the channel raises its status flag, copies a software-chosen level onto its output pin, and can request an interrupt.

Because the 16-bit value arrives one byte at a time, a write to the high byte stops all compares until the matching low-byte write arrives. A half-updated value therefore never produces a false match. The compare bytes and the status flag are not reset, so a warm reset keeps a programmed timeout. Software starts a channel by writing the high byte, reading the status location, and then writing the low byte. That sequence also clears any stale flag.

The bus register map, selected by `bus_addr`, is: 0 status (flag in bit 7), 1 control (bit 0 output level, bit 1 interrupt enable), 2 compare high byte, 3 compare low byte, 4 counter high byte, 5 counter low byte. Any other address reads zero.

Top module: `ocmp_channel`

## Requirements
- R1: The counter resets to 0 and advances by one on every PRESCALE-th clock (default 4) after reset is released. Its high and low bytes read back at addresses 4 and 5.
- R2: The compare high byte (address 2) and low byte (address 3) are written independently. A write to one leaves the other unchanged, and both read back exactly as written.
- R3: When the counter steps onto the compare value, the flag (bit 7 at address 0) is set on the clock edge after that step.
- R4: On every match, the output level bit (bit 0 at address 1) is copied to `cmp_pin` in the same edge that sets the flag, whether or not the flag was already set. `cmp_pin` resets to 0.
- R5: After a write to the high byte, no match is detected until the next low-byte write.
- R6: A low-byte write that has no preceding high-byte write does not block compares.
- R7: A low-byte write clears the flag only when an earlier status read saw the flag set. A low-byte write without such a read leaves the flag set.
- R8: `irq` is high exactly while both the flag and the interrupt enable bit (bit 1 at address 1) are set. It stays high until the flag is cleared.
- R9: A match is detected once for each counter value. Clearing the flag while the counter still holds the compare value does not set the flag again.
- R10: Reset leaves the compare bytes and the flag unchanged. It clears the counter, the control bits and the output pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| cmp_pin | output | 1 | Compare output level |
| irq | output | 1 | Compare interrupt request |

## Verification
The bench builds the channel with its default parameters: a 16-bit counter, an 8-bit bus and a prescale of 4. At a prescale of 4 the bench can predict the exact clock in which a match must appear, and can clear the flag while the counter still holds the matched value. The counter needs more than 260,000 clocks to wrap, so wrap-around is out of reach. Every match is aimed a few dozen counts ahead of the current counter value.

// File: rtl/ocmp_pkg.sv
// Shared definitions for the output compare channel.
// Assumes a register select of ADDR_W bits; the codes below are the bus map.
package ocmp_pkg;

    localparam int ADDR_W = 3;

    // Register select codes seen on the processor bus
    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_CTRL   = 3'd1,
        SEL_CMP_HI = 3'd2,
        SEL_CMP_LO = 3'd3,
        SEL_CNT_HI = 3'd4,
        SEL_CNT_LO = 3'd5
    } reg_sel_e;

    // Bit positions inside the control byte
    localparam int CTRL_LVL_BIT = 0;
    localparam int CTRL_IE_BIT  = 1;

endpackage

// File: rtl/ocmp_timebase.sv
// Prescaler and free-running up-counter.
// The counter advances once every PRESCALE clocks. It starts from zero on
// reset and wraps naturally. 'step' is high for one clock right after each
// counter update; the compare logic uses it as the "new counter value" strobe.
// Assumes PRESCALE >= 1.
module ocmp_timebase #(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count,
    output logic             step
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic tick;

    generate
        if (PRESCALE > 1) begin : g_div
            logic [PRE_W-1:0] pre;

            // Divide the bus clock down to the counter rate
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pre <= '0;
                else if (tick)
                    pre <= '0;
                else
                    pre <= pre + 1'b1;
            end

            assign tick = (pre == PRE_W'(PRESCALE - 1));

            // R1: a new counter value is never announced on two consecutive clocks
            a_r1_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                step |=> !step);
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    // Advance the counter on each prescaled tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end

    // Flag the clock in which a freshly updated counter value is present
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= 1'b0;
        else
            step <= tick;
    end

    // R1: the counter only moves together with the step strobe
    a_r1_count_with_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> step);

endmodule

// File: rtl/ocmp_cmpreg.sv
// Two-byte compare register with the high-then-low write interlock.
// Each byte is stored independently and is never reset.
// A high-byte write raises 'inhibit'; the next low-byte write drops it.
// Assumes CNT_W > BUS_W and CNT_W - BUS_W <= BUS_W.
module ocmp_cmpreg #(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] cmp_value,
    output logic             inhibit
);

    localparam int HI_W = CNT_W - BUS_W;

    logic [HI_W-1:0]  cmp_hi;
    logic [BUS_W-1:0] cmp_lo;

    // Capture the high byte; deliberately not touched by reset
    always_ff @(posedge clk) begin
        if (hi_wr)
            cmp_hi <= wdata[HI_W-1:0];
    end

    // Capture the low byte; deliberately not touched by reset
    always_ff @(posedge clk) begin
        if (lo_wr)
            cmp_lo <= wdata;
    end

    // Hold compares off between a high-byte write and the next low-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)
            inhibit <= 1'b0;
        else if (lo_wr)
            inhibit <= 1'b0;
        else if (hi_wr)
            inhibit <= 1'b1;
    end

    assign cmp_value = {cmp_hi, cmp_lo};

    // R2: a byte changes only after a write to that byte
    a_r2_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hi_wr) |-> $stable(cmp_hi));
    a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lo_wr) |-> $stable(cmp_lo));

    // R6: a low-byte write always leaves compares enabled afterwards
    a_r6_lo_enables: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> !inhibit);

endmodule

// File: rtl/ocmp_matcher.sv
// Match detection, the compare flag with its clear sequence, and the level latch.
// A match is taken only in the step clock, so each counter value is seen once.
// The flag is not reset. It clears on a low-byte write that follows a status
// read which saw the flag set. A set in the same clock wins over a clear.
module ocmp_matcher #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             step,
    input  logic [CNT_W-1:0] cmp_value,
    input  logic             inhibit,
    input  logic             lvl,
    input  logic             status_rd,
    input  logic             lo_wr,
    output logic             flag,
    output logic             pin
);

    logic hit;
    logic armed;

    assign hit = step && !inhibit && (count == cmp_value);

    // Remember that software has seen the flag set
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (lo_wr)
            armed <= 1'b0;
        else if (status_rd && flag)
            armed <= 1'b1;
    end

    // Compare flag: set on a match, cleared by the read-then-low-write sequence
    always_ff @(posedge clk) begin
        if (hit)
            flag <= 1'b1;
        else if (lo_wr && armed)
            flag <= 1'b0;
    end

    // Output level latch: take the programmed level on every match
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin <= 1'b0;
        else if (hit)
            pin <= lvl;
    end

    // R3 / R9: the flag rises only right after a fresh counter value
    a_r9_rise_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(step));

    // R4: a rising flag comes with the programmed level on the pin
    a_r4_level_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (pin == $past(lvl)));

    // R5: while compares are held off, a clear flag stays clear
    a_r5_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !flag) |=> !flag);

    // R7: the flag falls only through the armed low-byte write
    a_r7_clear_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(lo_wr && armed));

endmodule

// File: rtl/ocmp_channel.sv
// Output compare channel top: bus decode, control byte, read mux and interrupt.
// Assumes single-cycle read and write strobes that are never active together.
// Compare bytes and the flag keep their value through reset; the counter,
// the control bits and the pin reset.
module ocmp_channel #(
    parameter int CNT_W    = 16,
    parameter int BUS_W    = 8,
    parameter int PRESCALE = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ocmp_pkg::ADDR_W-1:0] bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    output logic                       cmp_pin,
    output logic                       irq
);

    import ocmp_pkg::*;

    localparam int HI_W     = CNT_W - BUS_W;
    localparam int FLAG_POS = BUS_W - 1;

    reg_sel_e         sel;
    logic             hi_wr, lo_wr, ctrl_wr, status_rd;
    logic             ctrl_lvl, ctrl_ie;
    logic [CNT_W-1:0] count, cmp_value;
    logic             step, inhibit, flag;

    assign sel       = reg_sel_e'(bus_addr);
    assign hi_wr     = bus_wr && (sel == SEL_CMP_HI);
    assign lo_wr     = bus_wr && (sel == SEL_CMP_LO);
    assign ctrl_wr   = bus_wr && (sel == SEL_CTRL);
    assign status_rd = bus_rd && (sel == SEL_STATUS);

    // Control byte: output level and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_lvl <= 1'b0;
            ctrl_ie  <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_lvl <= bus_wdata[CTRL_LVL_BIT];
            ctrl_ie  <= bus_wdata[CTRL_IE_BIT];
        end
    end

    ocmp_timebase #(
        .CNT_W    (CNT_W),
        .PRESCALE (PRESCALE)
    ) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count),
        .step  (step)
    );

    ocmp_cmpreg #(
        .CNT_W (CNT_W),
        .BUS_W (BUS_W)
    ) u_cmpreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_wr     (hi_wr),
        .lo_wr     (lo_wr),
        .wdata     (bus_wdata),
        .cmp_value (cmp_value),
        .inhibit   (inhibit)
    );

    ocmp_matcher #(
        .CNT_W (CNT_W)
    ) u_matcher (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count),
        .step      (step),
        .cmp_value (cmp_value),
        .inhibit   (inhibit),
        .lvl       (ctrl_lvl),
        .status_rd (status_rd),
        .lo_wr     (lo_wr),
        .flag      (flag),
        .pin       (cmp_pin)
    );

    // Read mux: present the selected register on the data bus
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_STATUS: bus_rdata[FLAG_POS] = flag;
            SEL_CTRL: begin
                bus_rdata[CTRL_LVL_BIT] = ctrl_lvl;
                bus_rdata[CTRL_IE_BIT]  = ctrl_ie;
            end
            SEL_CMP_HI: bus_rdata[HI_W-1:0] = cmp_value[CNT_W-1:BUS_W];
            SEL_CMP_LO: bus_rdata = cmp_value[BUS_W-1:0];
            SEL_CNT_HI: bus_rdata[HI_W-1:0] = count[CNT_W-1:BUS_W];
            SEL_CNT_LO: bus_rdata = count[BUS_W-1:0];
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = flag && ctrl_ie;

    // R8: with the enable held, a raised request drops only when the flag is cleared
    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && $stable(ctrl_ie) && ctrl_ie && !$fell(flag)) |-> irq);

endmodule

// File: tb/ocmp_channel_bench.sv
// Directed bench for the output compare channel.
module ocmp_channel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 4;
    localparam logic [2:0] A_STAT = 3'd0, A_CTRL = 3'd1, A_CHI = 3'd2,
                           A_CLO = 3'd3, A_NHI = 3'd4, A_NLO = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cmp_pin;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int edges = 0;
    bit done = 1'b0;

    ocmp_channel u_ocmp_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmp_pin   (cmp_pin),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Clock edges seen with reset released; the counter should equal edges/PRE
    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic prog(input int t);
        bus_write(A_CHI, 8'((t >> 8) & 255));
        bus_write(A_CLO, 8'(t & 255));
    endtask

    task automatic clear_flag();
        logic [7:0] lo, s;
        bus_read(A_CLO, lo);
        bus_read(A_STAT, s);
        bus_write(A_CLO, lo);
    endtask

    // Wait for irq (use_irq) or cmp_pin to reach val; returns edges at that moment
    task automatic wait_for(input bit use_irq, input logic val, output int at_edge);
        at_edge = -1;
        for (int i = 0; i < 1000; i++) begin
            if ((use_irq ? irq : cmp_pin) === val) begin
                at_edge = edges;
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk("R4", "pin after reset", int'(cmp_pin), 0);
        chk("R10", "ctrl after reset", 0, 0);
        bus_read(A_CTRL, d);
        chk("R10", "ctrl bits after reset", int'(d), 0);
        chk("R8", "irq after reset", int'(irq), 0);
        bus_read(A_NHI, d);
        chk("R1", "counter high after reset", int'(d), 0);
        // Software start sequence: high byte, status read, low byte
        bus_write(A_CHI, 8'hF0);
        bus_read(A_STAT, d);
        bus_write(A_CLO, 8'h00);
        bus_read(A_STAT, d);
        chk("R7", "flag after start sequence", int'(d), 0);
    endtask

    task automatic t_count();
        logic [7:0] d;
        for (int k = 0; k < 5; k++) begin
            repeat (7 + 3 * k) @(negedge clk);
            bus_addr = A_NLO;
            #1 chk("R1", "counter low byte", int'(bus_rdata), (edges / PRE) & 255);
            bus_read(A_NHI, d);
            chk("R1", "counter high byte", int'(d), ((edges - 1) / PRE) >> 8);
        end
    endtask

    task automatic t_bytes();
        logic [7:0] h, l;
        bus_write(A_CHI, 8'hA5);
        bus_write(A_CLO, 8'h3C);
        bus_read(A_CHI, h);
        bus_read(A_CLO, l);
        chk("R2", "high readback", int'(h), 8'hA5);
        chk("R2", "low readback", int'(l), 8'h3C);
        bus_write(A_CHI, 8'h5A);
        bus_read(A_CLO, l);
        chk("R2", "low kept after high write", int'(l), 8'h3C);
        bus_write(A_CLO, 8'hC3);
        bus_read(A_CHI, h);
        chk("R2", "high kept after low write", int'(h), 8'h5A);
    endtask

    task automatic t_match_basic();
        logic [7:0] d;
        int t, e;
        bus_write(A_CTRL, 8'h01);
        t = edges / PRE + 20;
        prog(t);
        wait_for(1'b0, 1'b1, e);
        chk("R3", "match clock (pin rise)", e, PRE * t + 1);
        chk("R8", "irq with enable off", int'(irq), 0);
        bus_read(A_STAT, d);
        chk("R3", "status flag after match", int'(d), 8'h80);
        bus_write(A_CTRL, 8'h03);
        chk("R8", "irq once enable set", int'(irq), 1);
        bus_write(A_CLO, 8'(t & 255));
        chk("R8", "irq after clear", int'(irq), 0);
        bus_read(A_STAT, d);
        chk("R7", "flag after read then low write", int'(d), 0);
    endtask

    task automatic t_irq_hold();
        logic [7:0] d;
        int t, e;
        bus_write(A_CTRL, 8'h02);
        t = edges / PRE + 20;
        prog(t);
        wait_for(1'b1, 1'b1, e);
        chk("R3", "match clock (irq rise)", e, PRE * t + 1);
        chk("R4", "pin takes level 0", int'(cmp_pin), 0);
        repeat (20) @(negedge clk);
        chk("R8", "irq held while flag set", int'(irq), 1);
        bus_write(A_CLO, 8'(t & 255));
        chk("R7", "low write without read keeps flag", int'(irq), 1);
        // Level moves to the pin although the flag is still set
        bus_write(A_CTRL, 8'h03);
        t = edges / PRE + 20;
        prog(t);
        wait_for(1'b0, 1'b1, e);
        chk("R4", "level copied with flag already set", e, PRE * t + 1);
        chk("R8", "irq still high", int'(irq), 1);
        bus_read(A_STAT, d);
        chk("R7", "status shows flag", int'(d), 8'h80);
        bus_write(A_CLO, 8'(t & 255));
        chk("R7", "irq after proper clear", int'(irq), 0);
    endtask

    task automatic t_interlock();
        int t, e;
        bus_write(A_CTRL, 8'h02);
        t = edges / PRE + 20;
        bus_write(A_CLO, 8'(t & 255));
        bus_write(A_CHI, 8'((t >> 8) & 255));
        while (edges < PRE * t + 24) @(negedge clk);
        chk("R5", "no flag while held off", int'(irq), 0);
        chk("R5", "pin untouched while held off", int'(cmp_pin), 1);
        t = edges / PRE + 20;
        prog(t);
        wait_for(1'b1, 1'b1, e);
        chk("R5", "compares resume after low write", e, PRE * t + 1);
        chk("R4", "pin takes level 0 on resumed match", int'(cmp_pin), 0);
    endtask

    task automatic t_lo_only();
        int t, e;
        clear_flag();
        t = edges / PRE + 20;
        prog(t);
        bus_write(A_CLO, 8'(t & 255));
        bus_write(A_CLO, 8'(t & 255));
        wait_for(1'b1, 1'b1, e);
        chk("R6", "match after low-only writes", e, PRE * t + 1);
    endtask

    task automatic t_once();
        logic [7:0] d;
        int t, e, seen;
        clear_flag();
        t = edges / PRE + 20;
        prog(t);
        wait_for(1'b1, 1'b1, e);
        chk("R9", "match clock", e, PRE * t + 1);
        bus_read(A_STAT, d);
        bus_write(A_CLO, 8'(t & 255));
        chk("R9", "cleared while counter unchanged", edges / PRE, t);
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            if (irq !== 1'b0) seen++;
            @(negedge clk);
        end
        chk("R9", "no repeated match", seen, 0);
    endtask

    task automatic t_reset_keep();
        logic [7:0] d;
        int t, e;
        bus_write(A_CTRL, 8'h03);
        t = edges / PRE + 20;
        prog(t);
        wait_for(1'b1, 1'b1, e);
        chk("R3", "match before reset", e, PRE * t + 1);
        do_reset();
        chk("R10", "pin cleared by reset", int'(cmp_pin), 0);
        chk("R10", "irq low after reset", int'(irq), 0);
        bus_read(A_STAT, d);
        chk("R10", "flag kept over reset", int'(d), 8'h80);
        bus_read(A_CHI, d);
        chk("R10", "compare high kept", int'(d), (t >> 8) & 255);
        bus_read(A_CLO, d);
        chk("R10", "compare low kept", int'(d), t & 255);
        bus_read(A_CTRL, d);
        chk("R10", "control cleared", int'(d), 0);
        bus_addr = A_NLO;
        #1 chk("R1", "counter restarted", int'(bus_rdata), edges / PRE);
    endtask

    initial begin
        t_reset();
        t_count();
        t_bytes();
        t_match_basic();
        t_irq_hold();
        t_interlock();
        t_lo_only();
        t_once();
        t_reset_keep();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule